// File: doc/BRIEF.md
# Per-Processor Counter Timer

This block is a counter/timer dedicated to one processor, reached through a small 32-bit register bus with four word offsets. A `user_mode` input, driven by a system-level controller, selects one of two personalities. In limit mode a 22-bit counter counts timebase ticks until it equals a programmed limit. It then wraps to zero, sets a reached flag and raises an interrupt that software acknowledges by reading the limit back. In user mode the same storage becomes a 54-bit free-running counter that software can start and stop. This counter never interrupts.

Counter and limit values are presented on the bus aligned to bit 9, so one counter unit is worth 512 in register terms. The counter moves by one unit on each `tick_en` pulse, and each pulse stands for 500 ns of time. A `reload_req` pulse returns the timer to its power-up condition, which is a maximum limit, a zero count and a running counter.

Top module: `ptmr_top`

## Requirements
- R1: The stored limit is the 22-bit field of bits 30:9 of the written word. In limit mode an offset-0 read returns that field at bits 30:9, and bits 31 and 8:0 read as 0.
- R2: A limit write whose bits 30:9 are all zero stores the all-ones field, which reads back as 0x7FFFFE00.
- R3: In limit mode, a write to offset 0 loads the limit, zeroes the counter and clears the interrupt. A write to offset 2 loads the limit and leaves the count unchanged.
- R4: In limit mode, a read of offset 0 clears both the interrupt and the reached flag.
- R5: In limit mode, a read of offset 1 returns the reached flag at bit 31 and the count at bits 30:9, with bits 8:0 at 0. This read has no side effect.
- R6: In limit mode, a tick that makes the count equal the limit returns the count to 0 and sets the reached flag and the interrupt. In user mode no count value raises the interrupt.
- R7: In user mode, offset 0 reads count bits 53:23 in word bits 30:0, and offset 1 reads count bits 22:0 in word bits 31:9 with bits 8:0 at 0. A write to either offset zeroes the counter and clears the interrupt.
- R8: In user mode, writing offset 3 with bit 0 = 1 runs the counter and bit 0 = 0 stops it. A write that repeats the current state changes nothing. In limit mode, writes to offset 3 are ignored. An offset-3 read returns the running status in bit 0 in both modes.
- R9: After reset the limit field is all ones, the count is 0, the reached flag and interrupt are clear, and the counter runs.
- R10: Each `tick_en` pulse advances a running counter by one unit, which is 0x200 in register terms. A stopped counter does not move.
- R11: A `reload_req` pulse restores the reset state of R9 and takes precedence over a bus write in the same cycle.
- R12: Offset 2 reads as 0. In limit mode, a write to offset 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timebase pulse, one counter unit |
| user_mode | input | 1 | 1 selects the free-running counter, 0 selects the limit timer |
| reload_req | input | 1 | Pulse that restores the power-up condition |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, which triggers read side effects |
| addr | input | 2 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Limit-reached interrupt |

## Verification
Three kinds of internal fault would show at the ports. A corrupted count appears in the offset-1 read as soon as it is taken. A wrong limit compare shows as `irq` rising one tick early or late relative to the programmed value. A stuck run flag shows as a count that does not change across a burst of ticks. The directed scenarios read the count right after each burst of ticks. They also sample `irq` on the cycle after each clearing read or write, so that an ordering fault between expiry, read acknowledge and counter reset is caught within one access.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DATA_W = 32;
  localparam int FRAC_W = 9;
  localparam int LIM_W  = 22;
  localparam int CNT_W  = 54;
  localparam int ADDR_W = 2;
  localparam int HI_LSB = DATA_W - FRAC_W;

  typedef enum logic [ADDR_W-1:0] {
    OFS_PRIMARY = 2'd0,
    OFS_COUNT   = 2'd1,
    OFS_LIMONLY = 2'd2,
    OFS_RUNCTL  = 2'd3
  } ofs_e;

  function automatic logic [LIM_W-1:0] limit_field(input logic [DATA_W-1:0] w);
    logic [LIM_W-1:0] f;
    f = w[FRAC_W +: LIM_W];
    return (f == '0) ? '1 : f;
  endfunction

  function automatic logic [DATA_W-1:0] place_field(input logic [LIM_W-1:0] f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FRAC_W +: LIM_W] = f;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] user_low(input logic [CNT_W-1:0] c);
    return {c[HI_LSB-1:0], {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] user_high(input logic [CNT_W-1:0] c);
    return DATA_W'(c[CNT_W-1:HI_LSB]);
  endfunction
endpackage

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             user_mode,
  input  logic             clr,
  input  logic [LIM_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] low_nxt;
  logic             step;

  assign step    = run && tick_en;
  assign low_nxt = cnt_q[LIM_W-1:0] + LIM_W'(1);
  assign expire  = step && !user_mode && (low_nxt == lim);
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (user_mode)   cnt_q <= cnt_q + CNT_W'(1);
      else if (expire) cnt_q <= {cnt_q[CNT_W-1:LIM_W], {LIM_W{1'b0}}};
      else             cnt_q <= {cnt_q[CNT_W-1:LIM_W], low_nxt};
    end
  end

  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
  p_expire_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !clr) |=> (cnt_q[LIM_W-1:0] == '0));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode,
  input  logic              reload,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [LIM_W-1:0]  lim,
  output logic              run,
  output logic              irq,
  output logic              reached,
  output logic              cnt_clr
);
  logic [LIM_W-1:0] lim_q;
  logic run_q, irq_q, reached_q;
  logic wr_primary, wr_count, rd_ack;

  assign wr_primary = wr_en && (addr == OFS_PRIMARY);
  assign wr_count   = wr_en && (addr == OFS_COUNT) && user_mode;
  assign rd_ack     = rd_en && (addr == OFS_PRIMARY) && !user_mode;
  assign cnt_clr    = reload || wr_primary || wr_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '1; run_q <= 1'b1; irq_q <= 1'b0; reached_q <= 1'b0;
    end else if (reload) begin
      lim_q <= '1; run_q <= 1'b1; irq_q <= 1'b0; reached_q <= 1'b0;
    end else begin
      if (rd_ack) begin
        irq_q     <= 1'b0;
        reached_q <= 1'b0;
      end
      if (wr_en) begin
        unique case (addr)
          OFS_PRIMARY: begin
            if (!user_mode) lim_q <= limit_field(wdata);
            irq_q <= 1'b0;
          end
          OFS_COUNT:   if (user_mode) irq_q <= 1'b0;
          OFS_LIMONLY: lim_q <= limit_field(wdata);
          OFS_RUNCTL:  if (user_mode && (wdata[0] != run_q)) run_q <= wdata[0];
          default: ;
        endcase
      end
      if (expire && !cnt_clr) begin
        irq_q     <= 1'b1;
        reached_q <= 1'b1;
      end
    end
  end

  assign lim     = lim_q;
  assign run     = run_q;
  assign irq     = irq_q;
  assign reached = reached_q;

  p_lim_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q != '0);
  p_irq_limit_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(!user_mode));
  p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cnt_clr && !reload) |=> (irq_q && reached_q));
  p_read_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !expire && !reload) |=> (!irq_q && !reached_q));
  p_wr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_primary |=> !irq_q);
  p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (run_q && (lim_q == '1) && !irq_q));
  p_limit_run_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && !reload) |=> $stable(run_q));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              reload_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [LIM_W-1:0] lim;
  logic [CNT_W-1:0] cnt;
  logic run, reached, cnt_clr, expire;

  ptmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .reload(reload_req),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .expire(expire), .lim(lim), .run(run), .irq(irq),
    .reached(reached), .cnt_clr(cnt_clr)
  );

  ptmr_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .user_mode(user_mode), .clr(cnt_clr), .lim(lim),
    .cnt(cnt), .expire(expire)
  );

  always_comb begin
    unique case (addr)
      OFS_PRIMARY: rdata = user_mode ? user_high(cnt) : place_field(lim);
      OFS_COUNT:   rdata = user_mode ? user_low(cnt)
                         : (place_field(cnt[LIM_W-1:0]) | {reached, {(DATA_W-1){1'b0}}});
      OFS_RUNCTL:  rdata = DATA_W'(run);
      default:     rdata = '0;
    endcase
  end

  p_user_no_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && $past(user_mode)) |-> !$rose(irq));
endmodule

// File: tb/ptmr_top_bench.sv
module ptmr_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, user_mode = 1'b0, reload_req = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int vec = 0, bad = 0;
  logic [31:0] got;

  always #4 clk = ~clk;

  ptmr_top u_ptmr_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .user_mode(user_mode),
    .reload_req(reload_req), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_lim(input logic [31:0] w);
    logic [31:0] m;
    m = w & 32'h7FFF_FE00;
    return (m == 32'd0) ? 32'h7FFF_FE00 : m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    peek(2'd0, got); chk("R9 limit", got, 32'h7FFF_FE00);
    peek(2'd1, got); chk("R9 count", got, 32'h0);
    peek(2'd3, got); chk("R9 running", got, 32'h1);
    chk("R9 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_limit_fields;
    wr(2'd0, 32'h0000_01FF); peek(2'd0, got); chk("R2 zero limit", got, 32'h7FFF_FE00);
    wr(2'd0, 32'hFFFF_FFFF); peek(2'd0, got); chk("R1 mask ones", got, exp_lim(32'hFFFF_FFFF));
    wr(2'd2, 32'h1234_5678); peek(2'd0, got); chk("R1 field", got, exp_lim(32'h1234_5678));
  endtask

  task automatic t_expiry;
    wr(2'd0, 32'd3 << 9);
    ticks(2); rd(2'd1, got); chk("R5 count", got, 32'd2 << 9);
    chk("R6 no early irq", {31'b0, irq}, 32'h0);
    ticks(1); chk("R6 irq set", {31'b0, irq}, 32'h1);
    rd(2'd1, got); chk("R5 reached and wrapped", got, 32'h8000_0000);
    chk("R5 no side effect", {31'b0, irq}, 32'h1);
    rd(2'd0, got); chk("R4 limit read", got, 32'd3 << 9);
    chk("R4 irq cleared", {31'b0, irq}, 32'h0);
    peek(2'd1, got); chk("R4 reached cleared", got, 32'h0);
    ticks(1); peek(2'd1, got); chk("R10 one unit", got, 32'h200);
  endtask

  task automatic t_rewrite;
    wr(2'd0, 32'd10 << 9); ticks(4);
    wr(2'd2, 32'd8 << 9); peek(2'd1, got); chk("R3 offset2 keeps count", got, 32'd4 << 9);
    ticks(3); chk("R3 no irq before new limit", {31'b0, irq}, 32'h0);
    ticks(1); chk("R3 expiry at new limit", {31'b0, irq}, 32'h1);
    ticks(2); wr(2'd0, 32'd8 << 9);
    chk("R3 offset0 clears irq", {31'b0, irq}, 32'h0);
    peek(2'd1, got); chk("R3 offset0 zeroes count", got, 32'h8000_0000);
    rd(2'd0, got);
  endtask

  task automatic t_undefined_limit;
    ticks(2);
    wr(2'd1, 32'hFFFF_FFFF); peek(2'd1, got); chk("R12 offset1 write ignored", got, 32'd2 << 9);
    peek(2'd2, got); chk("R12 offset2 reads 0", got, 32'h0);
    wr(2'd3, 32'h0); peek(2'd3, got); chk("R8 limit mode run write ignored", got, 32'h1);
  endtask

  task automatic t_user;
    wr(2'd0, 32'd3 << 9);
    @(negedge clk); user_mode = 1'b1;
    wr(2'd1, 32'h0);
    ticks(5);
    peek(2'd1, got); chk("R7 low word", got, 32'd5 << 9);
    peek(2'd0, got); chk("R7 high word", got, 32'h0);
    chk("R6 user mode no irq", {31'b0, irq}, 32'h0);
    peek(2'd2, got); chk("R12 user offset2", got, 32'h0);
    wr(2'd0, 32'h0); peek(2'd1, got); chk("R7 write resets", got, 32'h0);
  endtask

  task automatic t_runctl;
    ticks(2);
    wr(2'd3, 32'h0); peek(2'd3, got); chk("R8 stopped status", got, 32'h0);
    ticks(3); peek(2'd1, got); chk("R10 stopped holds", got, 32'd2 << 9);
    wr(2'd3, 32'h0); peek(2'd3, got); chk("R8 repeat stop", got, 32'h0);
    wr(2'd3, 32'h1); ticks(1); peek(2'd1, got); chk("R8 restart", got, 32'd3 << 9);
    peek(2'd3, got); chk("R8 running status", got, 32'h1);
  endtask

  task automatic t_reload;
    wr(2'd3, 32'h0);
    @(negedge clk); user_mode = 1'b0;
    wr(2'd2, 32'd5 << 9);
    @(negedge clk); reload_req = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 32'd7 << 9;
    @(negedge clk); reload_req = 1'b0; wr_en = 1'b0;
    peek(2'd3, got); chk("R11 running", got, 32'h1);
    peek(2'd1, got); chk("R11 count", got, 32'h0);
    peek(2'd0, got); chk("R11 limit max over write", got, 32'h7FFF_FE00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_limit_fields(); t_expiry(); t_rewrite();
        t_undefined_limit(); t_user(); t_runctl(); t_reload();
      end
      begin
        repeat (20000) @(posedge clk);
        bad++; vec++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule